// File: doc/BRIEF.md
# Multi-Mode Programmable Down-Counter Channel

This block is one 16-bit channel of an interval timer. A register front end hands it a mode number and, separately, a count value. The channel then counts down on a clock-enable tick. A gate input either holds counting or restarts it, depending on the mode. The channel drives an output pin that forms a one-shot, a periodic strobe, a square wave or a single strobe.

The live count and the output level are sent back to the front end, which latches them for software. Six counting behaviours are selected by a 3-bit mode code. A count of zero stands for the full range of 65536. Any new count load takes effect in the very next cycle.

Top module: `tmr_chan`

## Requirements
- R1: After reset, `out_o` is 0 and `count_o` is 0. The count does not move, even with ticks and gate high, until the first count load.
- R2: A write on `cnt_wr_i` puts the new value on `count_o` in the cycle after the write, replacing any count in progress. In mode 3 the value shown is rounded up to even. The output returns to its initial level: 0 in mode 0, 1 in all other modes.
- R3: A loaded value of 0 gives a terminal count after 65536 ticks. The first tick shows 0xFFFF.
- R4: In modes 0, 1, 4 and 5 each tick lowers the count by one. From 0 the count goes to 0xFFFF and does not reload.
- R5: In mode 0 the output is 0 after the load. It goes to 1 on the tick that brings the count to 0, and it stays 1 after the wrap.
- R6: In mode 1 the count holds after a load until the gate rises; the output is 1 during this wait. A gate rise reloads the programmed count and drives the output to 0. The output goes to 1 when the count reaches 0. A later gate rise restarts the count.
- R7: In mode 2 with a load of N, the count runs N, N-1, ..., 1. The next tick reloads N and drives the output to 0 for that one tick. The output is 1 otherwise.
- R8: In mode 3 the count steps down by 2 per tick. When it reaches 2, the next tick toggles the output and reloads. For even N each half lasts N/2 ticks. For odd N the high half lasts (N+1)/2 ticks and the low half (N-1)/2 ticks. Valid loads are N of 2 or more, or 0.
- R9: In modes 4 and 5 the output is 1, except for a single tick at 0 on the tick that brings the count to 0. Mode 5 counts only after a gate rise, which reloads the programmed count.
- R10: In modes 0, 2, 3 and 4 a low gate freezes the count. Modes 1 and 5 ignore the gate level while counting.
- R11: In modes 2 and 3 a gate rise reloads the programmed count and drives the output to 1.
- R12: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R13: With `tick_i` low, the count and the output hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| gate_i | input | 1 | Gate level and trigger |
| mode_wr_i | input | 1 | Mode write strobe; stops counting until the next count load |
| mode_val_i | input | 3 | Mode code 0 to 7 |
| cnt_wr_i | input | 1 | Count load strobe |
| cnt_val_i | input | 16 | Count value, 0 means 65536 |
| count_o | output | 16 | Live count |
| out_o | output | 1 | Output pin level |

## Verification
Most internal faults in this channel show up on `count_o` within one tick. Examples are a wrong step size, a reload that does not happen, or a gate that is ignored; each appears as a count that differs from the expected sequence. Faults in the output register or the one-shot flag may only show when the count reaches its terminal value. For that reason the bench follows every mode through at least one full terminal event and one step beyond it. The zero-load case is run to its 65536th tick, so that a fault in the range boundary shows at the edge where it occurs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    M_TC_HI    = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_STRB_SW  = 3'd4,
    M_STRB_HW  = 3'd5
  } mode_e;

  // codes 6 and 7 fold onto the periodic modes
  function automatic mode_e norm_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return mode_e'({1'b0, code[1:0]});
    else                    return mode_e'(code);
  endfunction

  function automatic logic is_hw_trig(input mode_e m);
    return (m == M_ONESHOT) || (m == M_STRB_HW);
  endfunction

  function automatic logic is_single_step(input mode_e m);
    return (m == M_TC_HI) || (m == M_ONESHOT) || (m == M_STRB_SW) || (m == M_STRB_HW);
  endfunction

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/tmr_step.sv
module tmr_step
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  mode_e          mode_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic [CW-1:0]  reload_i,
  input  logic           out_i,
  output logic [CW-1:0]  cnt_nx_o,
  output logic           hit_zero_o,
  output logic           reload_now_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic [CW-1:0] half_hi;
  logic [CW-1:0] half_lo;

  // odd counts put the extra tick in the high half
  assign half_hi = reload_i + CW'(reload_i[0]);
  assign half_lo = {reload_i[CW-1:1], 1'b0};

  always_comb begin
    cnt_nx_o     = cnt_i - ONE;
    hit_zero_o   = 1'b0;
    reload_now_o = 1'b0;
    case (mode_i)
      M_RATE: begin
        if (cnt_i == ONE) begin
          cnt_nx_o     = reload_i;
          reload_now_o = 1'b1;
        end
      end
      M_SQUARE: begin
        if (cnt_i == TWO) begin
          reload_now_o = 1'b1;
          cnt_nx_o     = out_i ? half_lo : half_hi;
        end else begin
          cnt_nx_o = cnt_i - TWO;
        end
      end
      default: hit_zero_o = (cnt_i == ONE);
    endcase
  end
endmodule

// File: rtl/tmr_out.sv
module tmr_out
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode_i,
  input  mode_e mode_new_i,
  input  logic  mode_wr_i,
  input  logic  cnt_wr_i,
  input  logic  trig_i,
  input  logic  adv_i,
  input  logic  hit_zero_i,
  input  logic  fired_i,
  input  logic  reload_now_i,
  output logic  out_o
);
  logic out_q, out_nx;

  always_comb begin
    out_nx = out_q;
    if (mode_wr_i)      out_nx = (mode_new_i != M_TC_HI);
    else if (cnt_wr_i)  out_nx = (mode_i != M_TC_HI);
    else if (trig_i)    out_nx = (mode_i != M_ONESHOT);
    else if (adv_i) begin
      case (mode_i)
        M_TC_HI, M_ONESHOT: if (hit_zero_i) out_nx = 1'b1;
        M_RATE:             out_nx = ~reload_now_i;
        M_SQUARE:           if (reload_now_i) out_nx = ~out_q;
        default:            out_nx = ~(hit_zero_i & ~fired_i);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_nx;
  end

  assign out_o = out_q;

  // R5: once high in mode 0, stays high until a new write
  p_tc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_TC_HI && out_q && !mode_wr_i && !cnt_wr_i) |=> out_q);

  // R9: strobe low lasts until the next tick only
  p_strobe_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == M_STRB_SW || mode_i == M_STRB_HW) && !out_q && adv_i
     && !mode_wr_i && !cnt_wr_i && !trig_i) |=> out_q);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          mode_wr_i,
  input  logic [MW-1:0] mode_val_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_val_i,
  output logic [CW-1:0] count_o,
  output logic          out_o
);
  logic rst_q_n;
  logic rise;

  mode_e         mode_q, mode_nx, mode_new;
  logic [CW-1:0] cnt_q, cnt_nx, reload_q, reload_nx;
  logic          loaded_q, loaded_nx;
  logic          armed_q, armed_nx;
  logic          fired_q, fired_nx;

  logic [CW-1:0] step_cnt;
  logic          hit_zero, reload_now;
  logic          gate_ok, adv, trig, out_w;
  logic [CW-1:0] load_hi;

  tmr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  tmr_gate_edge u_edge (.clk(clk), .rst_n(rst_q_n), .gate_i(gate_i), .rise_o(rise));

  tmr_step #(.CW(CW)) u_step (
    .mode_i(mode_q), .cnt_i(cnt_q), .reload_i(reload_q), .out_i(out_w),
    .cnt_nx_o(step_cnt), .hit_zero_o(hit_zero), .reload_now_o(reload_now)
  );

  assign mode_new = norm_mode(mode_val_i);
  assign gate_ok  = is_hw_trig(mode_q) ? armed_q : gate_i;
  assign adv      = tick_i & loaded_q & gate_ok;
  assign trig     = rise & loaded_q & (mode_q != M_TC_HI) & (mode_q != M_STRB_SW)
                    & ~cnt_wr_i & ~mode_wr_i;

  always_comb begin
    mode_nx   = mode_q;
    cnt_nx    = cnt_q;
    reload_nx = reload_q;
    loaded_nx = loaded_q;
    armed_nx  = armed_q;
    fired_nx  = fired_q;
    load_hi   = cnt_val_i + CW'(cnt_val_i[0]);
    if (mode_wr_i) begin
      mode_nx   = mode_new;
      loaded_nx = 1'b0;
      armed_nx  = 1'b0;
      fired_nx  = 1'b0;
    end else if (cnt_wr_i) begin
      reload_nx = cnt_val_i;
      cnt_nx    = (mode_q == M_SQUARE) ? load_hi : cnt_val_i;
      loaded_nx = 1'b1;
      armed_nx  = 1'b0;
      fired_nx  = 1'b0;
    end else if (trig) begin
      cnt_nx   = (mode_q == M_SQUARE) ? reload_q + CW'(reload_q[0]) : reload_q;
      armed_nx = 1'b1;
      fired_nx = 1'b0;
    end else if (adv) begin
      cnt_nx = step_cnt;
      if (hit_zero) fired_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q   <= M_TC_HI;
      cnt_q    <= '0;
      reload_q <= '0;
      loaded_q <= 1'b0;
      armed_q  <= 1'b0;
      fired_q  <= 1'b0;
    end else begin
      mode_q   <= mode_nx;
      cnt_q    <= cnt_nx;
      reload_q <= reload_nx;
      loaded_q <= loaded_nx;
      armed_q  <= armed_nx;
      fired_q  <= fired_nx;
    end
  end

  tmr_out u_out (
    .clk(clk), .rst_n(rst_q_n), .mode_i(mode_q), .mode_new_i(mode_new),
    .mode_wr_i(mode_wr_i), .cnt_wr_i(cnt_wr_i), .trig_i(trig), .adv_i(adv),
    .hit_zero_i(hit_zero), .fired_i(fired_q), .reload_now_i(reload_now),
    .out_o(out_w)
  );

  assign count_o = cnt_q;
  assign out_o   = out_w;

  // R1: nothing moves before the first load
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!loaded_q && !cnt_wr_i) |=> $stable(cnt_q));

  // R2: a load shows up in the next cycle
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cnt_wr_i && !mode_wr_i && mode_q != M_SQUARE) |=> (cnt_q == $past(cnt_val_i)));

  // R4: single-step modes wrap instead of reloading
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (adv && is_single_step(mode_q) && cnt_q == '0 && !cnt_wr_i && !mode_wr_i && !trig)
    |=> (cnt_q == '1));

  // R8: square-wave count stays even
  p_sq_even_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (loaded_q && mode_q == M_SQUARE) |-> !cnt_q[0]);

  // R13: no tick, no motion
  p_tick_hold_r13: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!tick_i && !cnt_wr_i && !trig) |=> $stable(cnt_q));
endmodule

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick, gate, mode_wr, cnt_wr;
  logic [2:0]  mode_val;
  logic [15:0] cnt_val;
  logic [15:0] count;
  logic        outp;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  tmr_chan u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .gate_i(gate),
    .mode_wr_i(mode_wr), .mode_val_i(mode_val), .cnt_wr_i(cnt_wr),
    .cnt_val_i(cnt_val), .count_o(count), .out_o(outp)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic st(input string req, input logic [15:0] c, input logic o);
    chk(req, count, c);
    chk(req, {15'd0, outp}, {15'd0, o});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode_wr = 1'b1; mode_val = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    cnt_wr = 1'b1; cnt_val = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic t_reset;
    st("R1 reset", 16'h0000, 1'b0);
    step(5);
    st("R1 idle", 16'h0000, 1'b0);
  endtask

  task automatic t_mode0;
    gate = 1'b1;
    set_mode(3'd0);
    load(16'd5);
    st("R2 load m0", 16'd5, 1'b0);
    step(4);
    st("R4 m0 count", 16'd1, 1'b0);
    step(1);
    st("R5 m0 terminal", 16'd0, 1'b1);
    step(1);
    st("R4 R5 m0 wrap", 16'hFFFF, 1'b1);
    load(16'd100);
    step(3);
    chk("R4 m0 dec", count, 16'd97);
    load(16'd7);
    st("R2 reload mid", 16'd7, 1'b0);
    gate = 1'b0;
    step(3);
    chk("R10 m0 gate low", count, 16'd7);
    gate = 1'b1;
    tick = 1'b0;
    step(3);
    st("R13 tick low", 16'd7, 1'b0);
    tick = 1'b1;
    step(1);
    chk("R13 tick back", count, 16'd6);
  endtask

  task automatic t_zero;
    set_mode(3'd0);
    load(16'd0);
    step(1);
    chk("R3 first tick", count, 16'hFFFF);
    step(65534);
    st("R3 before end", 16'd1, 1'b0);
    step(1);
    st("R3 at 65536", 16'd0, 1'b1);
  endtask

  task automatic t_mode1;
    gate = 1'b0;
    set_mode(3'd1);
    load(16'd3);
    st("R6 loaded", 16'd3, 1'b1);
    step(2);
    st("R6 waits", 16'd3, 1'b1);
    gate = 1'b1;
    step(1);
    st("R6 trigger", 16'd3, 1'b0);
    step(2);
    st("R6 count", 16'd1, 1'b0);
    step(1);
    st("R6 terminal", 16'd0, 1'b1);
    gate = 1'b0;
    step(1);
    st("R10 m1 gate ignored", 16'hFFFF, 1'b1);
    gate = 1'b1;
    step(1);
    st("R6 retrigger", 16'd3, 1'b0);
  endtask

  task automatic t_mode2;
    gate = 1'b1;
    set_mode(3'd2);
    load(16'd4);
    st("R7 loaded", 16'd4, 1'b1);
    step(3);
    st("R7 at one", 16'd1, 1'b1);
    step(1);
    st("R7 reload pulse", 16'd4, 1'b0);
    step(1);
    st("R7 after pulse", 16'd3, 1'b1);
    load(16'd5);
    step(2);
    chk("R7 m2 run", count, 16'd3);
    gate = 1'b0;
    step(1);
    chk("R10 m2 gate low", count, 16'd3);
    gate = 1'b1;
    step(1);
    st("R11 m2 restart", 16'd5, 1'b1);
  endtask

  task automatic t_mode3;
    logic [15:0] ec [6];
    logic        eo [6];
    ec = '{16'd4, 16'd2, 16'd6, 16'd4, 16'd2, 16'd6};
    eo = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
    gate = 1'b1;
    set_mode(3'd3);
    load(16'd6);
    st("R8 even load", 16'd6, 1'b1);
    for (int i = 0; i < 6; i++) begin
      step(1);
      st("R8 even seq", ec[i], eo[i]);
    end
    ec = '{16'd4, 16'd2, 16'd4, 16'd2, 16'd6, 16'd0};
    eo = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    load(16'd5);
    st("R8 odd load", 16'd6, 1'b1);
    for (int i = 0; i < 5; i++) begin
      step(1);
      st("R8 odd seq", ec[i], eo[i]);
    end
    load(16'd8);
    step(1);
    chk("R8 m3 run", count, 16'd6);
    gate = 1'b0;
    step(1);
    chk("R10 m3 gate low", count, 16'd6);
    gate = 1'b1;
    step(1);
    st("R11 m3 restart", 16'd8, 1'b1);
  endtask

  task automatic t_strobe;
    gate = 1'b1;
    set_mode(3'd4);
    load(16'd3);
    st("R9 m4 load", 16'd3, 1'b1);
    step(2);
    st("R9 m4 at one", 16'd1, 1'b1);
    step(1);
    st("R9 m4 pulse", 16'd0, 1'b0);
    step(1);
    st("R9 m4 after", 16'hFFFF, 1'b1);
    gate = 1'b0;
    set_mode(3'd5);
    load(16'd2);
    step(2);
    st("R9 m5 waits", 16'd2, 1'b1);
    gate = 1'b1;
    step(1);
    st("R9 m5 trigger", 16'd2, 1'b1);
    step(2);
    st("R9 m5 pulse", 16'd0, 1'b0);
    step(1);
    st("R9 R4 m5 after", 16'hFFFF, 1'b1);
  endtask

  task automatic t_alias;
    gate = 1'b1;
    set_mode(3'd6);
    load(16'd3);
    step(2);
    st("R12 m6 at one", 16'd1, 1'b1);
    step(1);
    st("R12 m6 pulse", 16'd3, 1'b0);
    set_mode(3'd7);
    load(16'd4);
    st("R12 m7 load", 16'd4, 1'b1);
    step(2);
    st("R12 m7 toggle", 16'd4, 1'b0);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; gate = 1'b1;
    mode_wr = 1'b0; cnt_wr = 1'b0; mode_val = 3'd0; cnt_val = 16'd0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_strobe();
    t_alias();
    t_zero();
    finish_run();
  end
endmodule